// File: doc/BRIEF.md
# Hardwired Parallel Conjunction Matcher

This block compares one event against a fixed set of subscriptions that are built into the logic itself, so no memory is read. An event is a vector of unsigned attribute values, offered with a valid strobe. Each subscription is an AND of a small number of predicates. A predicate compares one attribute of the event either with a constant or with another attribute of the same event. Every predicate of every subscription is evaluated in the cycle the event is accepted.

The block stores the hit vector in a register. In the next cycle it tallies the hits into a count, and it finds the lowest-numbered matching subscription, with a flag for the case where nothing matched. The tallied result goes to a downstream queue through a write strobe, and only while that queue reports that it is not full. A small control unit gives both stages their advance enables. This allows one event per cycle at peak rate. When the queue is full, the pipeline holds its contents and closes the input.

The subscription table is an elaboration-time parameter: an array of predicate records, with one slot for each predicate of each subscription.

Top module: `conj_matcher`

## Requirements
- R1: Predicate operator codes are 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal. All comparisons are unsigned on ATTR_W-bit values, with the selected attribute on the left-hand side.
- R2: A predicate whose right-hand-select flag is set compares against another attribute of the same event instead of its constant.
- R3: Operator codes 6 and 7 mark an unused slot, which always evaluates true.
- R4: A subscription hits exactly when all of its predicate slots are true, and every subscription is evaluated against the same event.
- R5: `q_count` equals the number of subscriptions that hit the event.
- R6: `q_index` is the lowest-numbered hitting subscription. When no subscription hits, `q_none` is 1 and `q_index` and `q_count` are 0; otherwise `q_none` is 0.
- R7: With the queue not full, the result of an event accepted at clock edge k is offered on `q_wr` in the cycle that ends at edge k+2, and it is written at that edge.
- R8: While `q_full` stays low, `in_ready` stays high, so an event can be accepted on every edge.
- R9: While `q_full` is high, `q_wr` stays low and the pending result holds steady. Once both stages are occupied, `in_ready` drops. Results reach the queue in acceptance order, with none lost or duplicated.
- R10: After reset, `in_ready` is 1 and `q_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An event is presented |
| in_ready | output | 1 | The event is accepted at the edge when in_valid is also high |
| in_attrs | input | NUM_ATTR*ATTR_W | Attribute values; attribute j occupies bits j*ATTR_W and up |
| q_full | input | 1 | The downstream queue cannot take a write |
| q_wr | output | 1 | Write strobe into the queue |
| q_count | output | CNT_W | Number of hitting subscriptions |
| q_index | output | IDX_W | Lowest hitting subscription |
| q_none | output | 1 | No subscription hit |

## Verification
A wrong comparator or a mis-wired slot shows up two edges after the event is accepted, as a count or index that differs from the model. The bench's mix of random and directed attribute values hits each operator on both sides of its constant. A broken advance enable in the control unit has a different signature: a result that is lost, duplicated, reordered or late. The bench catches it at the next write, or in the queue left over once the final drain ends. A hold that leaks while the queue is full appears as a write strobe during a stall, in the first cycle of that stall.

// File: rtl/cmatch_pkg.sv
package cmatch_pkg;
    localparam int ATTR_W       = 8;
    localparam int NUM_ATTR     = 4;
    localparam int NUM_SUBS     = 8;
    localparam int PRED_PER_SUB = 2;
    localparam int AIDX_W       = $clog2(NUM_ATTR);
    localparam int NUM_PRED     = NUM_SUBS * PRED_PER_SUB;
    localparam int CNT_W        = $clog2(NUM_SUBS + 1);
    localparam int IDX_W        = $clog2(NUM_SUBS);
    localparam int EV_W         = NUM_ATTR * ATTR_W;

    typedef enum logic [2:0] {
        OP_EQ = 3'd0, OP_NE = 3'd1, OP_LT = 3'd2,
        OP_LE = 3'd3, OP_GT = 3'd4, OP_GE = 3'd5,
        OP_ANY = 3'd6, OP_ANY_B = 3'd7
    } op_e;

    typedef struct packed {
        logic              rhs_attr;
        logic [AIDX_W-1:0] lhs;
        op_e               op;
        logic [AIDX_W-1:0] rhs;
        logic [ATTR_W-1:0] cval;
    } pred_t;

    typedef pred_t [NUM_PRED-1:0] table_t;

    function automatic pred_t mk_c(int a, op_e o, int c);
        pred_t p;
        p.rhs_attr = 1'b0;
        p.lhs      = AIDX_W'(a);
        p.op       = o;
        p.rhs      = '0;
        p.cval     = ATTR_W'(c);
        return p;
    endfunction

    function automatic pred_t mk_a(int a, op_e o, int b);
        pred_t p;
        p.rhs_attr = 1'b1;
        p.lhs      = AIDX_W'(a);
        p.op       = o;
        p.rhs      = AIDX_W'(b);
        p.cval     = '0;
        return p;
    endfunction

    // slot index = subscription * PRED_PER_SUB + predicate
    function automatic table_t default_table();
        table_t t;
        pred_t  unused;
        unused = mk_c(0, OP_ANY, 0);
        t[0]  = mk_c(0, OP_EQ, 10);   t[1]  = unused;
        t[2]  = mk_c(1, OP_GT, 100);  t[3]  = mk_c(2, OP_LT, 50);
        t[4]  = mk_a(0, OP_LT, 1);    t[5]  = mk_c(3, OP_NE, 0);
        t[6]  = mk_a(2, OP_GE, 3);    t[7]  = mk_c(0, OP_LE, 200);
        t[8]  = mk_a(3, OP_EQ, 0);    t[9]  = mk_c(1, OP_ANY_B, 0);
        t[10] = mk_c(1, OP_LE, 20);   t[11] = mk_c(1, OP_GE, 10);
        t[12] = mk_c(2, OP_GT, 250);  t[13] = unused;
        t[14] = mk_c(3, OP_EQ, 255);  t[15] = mk_c(0, OP_EQ, 0);
        return t;
    endfunction
endpackage

// File: rtl/conj_pred_cmp.sv
module conj_pred_cmp
    import cmatch_pkg::*;
#(
    parameter pred_t CFG = '0
) (
    input  logic [EV_W-1:0] attrs,
    output logic            ok
);
    logic [ATTR_W-1:0] lhs_v;
    logic [ATTR_W-1:0] rhs_v;

    always_comb begin
        lhs_v = attrs[int'(CFG.lhs)*ATTR_W +: ATTR_W];
        rhs_v = CFG.rhs_attr ? attrs[int'(CFG.rhs)*ATTR_W +: ATTR_W] : CFG.cval;
        case (CFG.op)
            OP_EQ:   ok = (lhs_v == rhs_v);
            OP_NE:   ok = (lhs_v != rhs_v);
            OP_LT:   ok = (lhs_v <  rhs_v);
            OP_LE:   ok = (lhs_v <= rhs_v);
            OP_GT:   ok = (lhs_v >  rhs_v);
            OP_GE:   ok = (lhs_v >= rhs_v);
            default: ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/conj_hit_stage.sv
module conj_hit_stage
    import cmatch_pkg::*;
#(
    parameter table_t SUB_TABLE = default_table()
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                drain,
    input  logic [EV_W-1:0]     attrs,
    output logic                hvld,
    output logic [NUM_SUBS-1:0] hits
);
    typedef struct packed {
        logic                vld;
        logic [NUM_SUBS-1:0] hits;
    } hst_t;

    logic [NUM_PRED-1:0] slot_ok;
    logic [NUM_SUBS-1:0] sub_hit;
    hst_t st_d, st_q;

    for (genvar g = 0; g < NUM_PRED; g++) begin : g_slot
        conj_pred_cmp #(.CFG(SUB_TABLE[g])) i_cmp (
            .attrs (attrs),
            .ok    (slot_ok[g])
        );
    end

    for (genvar s = 0; s < NUM_SUBS; s++) begin : g_sub
        assign sub_hit[s] = &slot_ok[s*PRED_PER_SUB +: PRED_PER_SUB];
    end

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.vld  = 1'b1;
            st_d.hits = sub_hit;
        end else if (drain) begin
            st_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hvld = st_q.vld;
    assign hits = st_q.hits;

    // R7
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> hvld);
endmodule

// File: rtl/conj_tally.sv
module conj_tally
    import cmatch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [NUM_SUBS-1:0] hits,
    input  logic                q_full,
    output logic                rvld,
    output logic [CNT_W-1:0]    count,
    output logic [IDX_W-1:0]    index,
    output logic                none
);
    typedef struct packed {
        logic             vld;
        logic [CNT_W-1:0] count;
        logic [IDX_W-1:0] index;
        logic             none;
    } tst_t;

    tst_t st_d, st_q;
    logic [CNT_W-1:0] pop;
    logic [IDX_W-1:0] low;

    always_comb begin
        pop = '0;
        low = '0;
        for (int i = NUM_SUBS - 1; i >= 0; i--) begin
            pop = pop + CNT_W'(hits[i]);
            if (hits[i]) low = IDX_W'(i);
        end
        st_d = st_q;
        if (load) begin
            st_d.vld   = 1'b1;
            st_d.count = pop;
            st_d.index = low;
            st_d.none  = ~|hits;
        end else if (st_q.vld && !q_full) begin
            st_d.vld   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rvld  = st_q.vld;
    assign count = st_q.count;
    assign index = st_q.index;
    assign none  = st_q.none;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvld && q_full) |=> (rvld && $stable(count) && $stable(index) && $stable(none)));
    // R6
    none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvld && none) |-> (count == '0 && index == '0));
    // R5
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvld |-> (int'(count) <= NUM_SUBS && (none || count != '0)));
endmodule

// File: rtl/conj_matcher.sv
module conj_matcher
    import cmatch_pkg::*;
#(
    parameter table_t SUB_TABLE = default_table()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [EV_W-1:0]  in_attrs,
    input  logic             q_full,
    output logic             q_wr,
    output logic [CNT_W-1:0] q_count,
    output logic [IDX_W-1:0] q_index,
    output logic             q_none
);
    logic                hvld;
    logic [NUM_SUBS-1:0] hits;
    logic                rvld;
    logic                t_take;
    logic                t_load;
    logic                accept;

    // shared control: one enable per stage, all slots move together
    always_comb begin
        t_take   = !rvld || !q_full;
        t_load   = hvld && t_take;
        in_ready = !hvld || t_take;
        accept   = in_valid && in_ready;
        q_wr     = rvld && !q_full;
    end

    conj_hit_stage #(.SUB_TABLE(SUB_TABLE)) i_hit (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .drain (t_load),
        .attrs (in_attrs),
        .hvld  (hvld),
        .hits  (hits)
    );

    conj_tally i_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (t_load),
        .hits   (hits),
        .q_full (q_full),
        .rvld   (rvld),
        .count  (q_count),
        .index  (q_index),
        .none   (q_none)
    );

    // R8
    ready_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_full |-> in_ready);
    // R9
    ready_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hvld && rvld && q_full) |-> !in_ready);
endmodule

// File: tb/test_conj_matcher.sv
module test_conj_matcher;
    import cmatch_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [EV_W-1:0]  in_attrs = '0;
    logic             q_full = 1'b0;
    logic             q_wr;
    logic [CNT_W-1:0] q_count;
    logic [IDX_W-1:0] q_index;
    logic             q_none;

    always #10 clk = ~clk;

    conj_matcher i_conj_matcher (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_full = -1;
    bit done = 0;
    int exp_cnt[$];
    int exp_idx[$];
    int exp_none[$];
    int exp_cyc[$];
    localparam table_t TBL = default_table();

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: run hung, got cyc=%0d expected finish", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int attr_of(logic [EV_W-1:0] ev, int j);
        return int'(ev[j*ATTR_W +: ATTR_W]);
    endfunction

    // R1 R2 R3: model of one predicate, unsigned integers
    function automatic bit model_pred(pred_t p, logic [EV_W-1:0] ev);
        int l = attr_of(ev, int'(p.lhs));
        int r = p.rhs_attr ? attr_of(ev, int'(p.rhs)) : int'(p.cval);
        int code = int'(p.op);
        if (code >= 6) return 1;
        if (code == 0) return l == r;
        if (code == 1) return l != r;
        if (code == 2) return l < r;
        if (code == 3) return l <= r;
        if (code == 4) return l > r;
        return l >= r;
    endfunction

    // R4 R5 R6: expected tally
    task automatic predict(logic [EV_W-1:0] ev);
        int n = 0, lo = -1;
        for (int s = 0; s < NUM_SUBS; s++) begin
            bit all = 1;
            for (int k = 0; k < PRED_PER_SUB; k++)
                if (!model_pred(TBL[s*PRED_PER_SUB + k], ev)) all = 0;
            if (all) begin n++; if (lo < 0) lo = s; end
        end
        exp_cnt.push_back(n);
        exp_idx.push_back(lo < 0 ? 0 : lo);
        exp_none.push_back(lo < 0);
        exp_cyc.push_back(cyc);
    endtask

    task automatic step(bit v, logic [EV_W-1:0] ev, bit full);
        @(negedge clk);
        in_valid = v; in_attrs = ev; q_full = full;
        #1;
        if (full) last_full = cyc;
        if (full) check("R9 write during full", int'(q_wr), 0);
        if (in_valid && in_ready) predict(ev);
        if (q_wr) begin
            if (exp_cnt.size() == 0) begin
                check("R9 unexpected result", 1, 0);
            end else begin
                int ec = exp_cnt.pop_front();
                int ei = exp_idx.pop_front();
                int en = exp_none.pop_front();
                int ac = exp_cyc.pop_front();
                check("R4/R5 count", int'(q_count), ec);
                check("R6 index", int'(q_index), ei);
                check("R6 none", int'(q_none), en);
                if (last_full < ac) check("R7 latency", cyc - ac, 2);
            end
        end
    endtask

    function automatic logic [EV_W-1:0] mk_ev(int a0, int a1, int a2, int a3);
        return {ATTR_W'(a3), ATTR_W'(a2), ATTR_W'(a1), ATTR_W'(a0)};
    endfunction

    function automatic int pick();
        int sel = int'($urandom_range(0, 9));
        case (sel)
            0: return 0;  1: return 10; 2: return 15; 3: return 20;
            4: return 50; 5: return 100; 6: return 200; 7: return 255;
            8: return 251;
            default: return int'($urandom_range(0, 255));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R10 ready after reset", int'(in_ready), 1);
        check("R10 no write after reset", int'(q_wr), 0);

        // directed corners: none, highest index, several hits, unsigned top values
        step(1, mk_ev(5, 0, 0, 9), 0);        // R6 no hit at all
        step(1, mk_ev(0, 0, 0, 255), 0);      // R6 only subscription 7
        step(1, mk_ev(10, 15, 0, 0), 0);      // R4 subs 0,3,5
        step(1, mk_ev(0, 101, 251, 7), 0);    // R1 unsigned 251 > 250
        step(1, mk_ev(3, 200, 9, 9), 0);      // R2 attribute compares
        step(1, mk_ev(10, 9, 0, 10), 0);      // R3 unused slot passes
        repeat (4) step(0, '0, 0);

        // R8 back-to-back acceptance
        for (int i = 0; i < 20; i++) begin
            step(1, mk_ev(pick(), pick(), pick(), pick()), 0);
            check("R8 ready every cycle", int'(in_ready), 1);
        end
        repeat (4) step(0, '0, 0);

        // R9 stall: fill both stages, ready must drop
        step(1, mk_ev(10, 15, 0, 0), 1);
        step(1, mk_ev(0, 0, 0, 255), 1);
        step(1, mk_ev(5, 0, 0, 9), 1);
        check("R9 ready closed when full", int'(in_ready), 0);
        step(1, mk_ev(5, 0, 0, 9), 1);
        step(0, '0, 0);
        repeat (4) step(0, '0, 0);

        // random mix with random queue pressure
        for (int i = 0; i < 600; i++)
            step(bit'($urandom_range(0, 3) != 0), mk_ev(pick(), pick(), pick(), pick()),
                 bit'($urandom_range(0, 4) == 0));

        repeat (6) step(0, '0, 0);
        check("R9 nothing lost", exp_cnt.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule